// File: doc/BRIEF.md
# NAND Prefetch and Write-Posting Engine

This block is a byte-organised FIFO engine placed between a host data port and a simple NAND device port. In prefetch mode it reads a programmed number of bytes from an 8-bit or 16-bit device into a 64-byte FIFO, ahead of host reads. In write-posting mode it takes host writes into the FIFO and drains them to the device. Host accesses of one, two or four bytes are packed into and unpacked from the byte FIFO in little-endian order. The device side moves single bytes or 16-bit words, depending on the programmed device width. Every status value counts bytes.

Software first programs mode, device width, chip-select link, threshold and transfer count, then sets the start bit. While the start bit is high, the configuration is locked. The engine clears the start bit itself when the work is done. A threshold request line tells an interrupt controller or a DMA engine when the FIFO holds enough data, or enough free room, for a burst.

A host read that finds the FIFO empty returns the last byte read. A host write that finds the FIFO full overwrites the last byte location. Neither case raises a flag.

Back-pressure rules:
- Host port: `host_ready` depends only on the enable bit and on the chip-select match. For a hit it is always high, so the engine never stalls an access. A transfer happens on a clock edge where `host_valid` and `host_ready` are both high.
- Device port: `dev_req` is the valid of the device port and `dev_ack` is its ready. The engine holds `dev_req` for as long as the acknowledge stays low. Read data is sampled on the edge where both are high.

Top module: `nand_fifo_engine`

## Requirements
- R1: Configuration register map.
  - Address 0 is control; bit 0 is start, and writing 1 sets it.
  - Address 1 is mode: bit 0 enable, bit 1 write-posting (0 = prefetch), bit 2 16-bit device, bits [6:4] chip-select, bits [14:8] threshold.
  - Address 2 holds the transfer count in bits [13:0].
  - `cfg_rdata` reads back the addressed register.
  - Every configuration write, including a write to start, is ignored while start is high.
  - Setting start flushes the FIFO and loads the remaining byte count.
- R2: A host access is taken only when enable is set and `host_cs` equals the programmed chip-select. For any other access `host_ready` is low and FIFO state is unchanged.
- R3: The number of bytes moved by a host access equals the number of set byte enables. Those bytes map to the set lanes in ascending lane order, with the lowest set lane holding the earliest FIFO byte. Lanes that are not enabled read as zero.
- R4: With an 8-bit device (mode bit 2 = 0), each device transfer moves one byte on `dev_wdata[7:0]` / `dev_rdata[7:0]`, and the count and threshold are in bytes.
- R5: With a 16-bit device, each transfer moves two bytes, with the low byte first in the FIFO, and `dev_wide` is high. The count and threshold are then in 16-bit words.
- R6: `fifo_ptr` reports, in bytes, the bytes available to read in prefetch mode and the free slots in write-posting mode.
- R7: `count_left` reports the bytes still to be moved by the device side. It starts at the count converted to bytes and falls by the bytes of each transfer.
- R8: In prefetch mode, read lanes beyond the bytes available in the FIFO return the last byte read. When the FIFO is empty, every requested lane returns that byte.
- R9: In write-posting mode, bytes of a host write that do not fit overwrite the last FIFO location, which ends up holding the final byte of the write. The FIFO level does not change.
- R10: `thr_req` is high while enable is set and the `fifo_ptr` value is at or above the threshold converted to bytes.
- R11: Start clears itself when `count_left` is zero. In write-posting mode the FIFO must also be empty.
- R12: `dev_req` is asserted only while start is high, bytes remain, and there is FIFO room (prefetch) or FIFO data (write-posting). `dev_cs` carries the programmed chip-select, and `dev_we` is high in write-posting mode.
- R13: A hit read returns its data on `host_rdata` with `host_rvalid` high in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read-back of the addressed register |
| host_valid | input | 1 | Host access valid |
| host_ready | output | 1 | Host access accepted (hit) |
| host_write | input | 1 | Host access is a write |
| host_cs | input | 3 | Chip-select region of the host access |
| host_be | input | 4 | Host byte enables, contiguous |
| host_wdata | input | 32 | Host write data |
| host_rvalid | output | 1 | Host read data valid |
| host_rdata | output | 32 | Host read data |
| dev_req | output | 1 | Device transfer request |
| dev_ack | input | 1 | Device transfer acknowledge |
| dev_we | output | 1 | Device transfer is a write |
| dev_cs | output | 3 | Device chip-select |
| dev_wide | output | 1 | 16-bit device transfer |
| dev_wdata | output | 16 | Device write data |
| dev_rdata | input | 16 | Device read data |
| fifo_ptr | output | 7 | Bytes available or free slots |
| count_left | output | 14 | Bytes remaining for the device side |
| busy | output | 1 | Start bit |
| thr_req | output | 1 | Threshold request |

## Verification
Prefetch runs with an 8-bit device and with a 16-bit device show whether byte and word transfers, and byte-based status, are told apart correctly. A sequence of host reads of four, two and one byte, the last one on an upper lane, drains the FIFO past empty. This separates correct packing from repeat-last-byte behaviour. Write-posting runs use full-word and sparse-lane writes, then overfill the FIFO, to show whether excess bytes overwrite only the last slot. Configuration writes during a held transfer and accesses to a foreign chip-select check that locked or unmatched inputs leave state unchanged.

// File: rtl/nfe_pkg.sv
package nfe_pkg;
  localparam int CNT_W = 14;
  localparam int THR_W = 7;
  localparam int CS_W  = 3;
  localparam int NLANE = 4;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_MODE = 2'd1;
  localparam logic [1:0] A_CNT  = 2'd2;

  typedef struct packed {
    logic             enable;
    logic             wpost;
    logic             wide;
    logic [CS_W-1:0]  cs;
    logic [THR_W-1:0] thr;
    logic [CNT_W-1:0] count;
  } nfe_cfg_t;
endpackage

// File: rtl/nfe_regs.sv
module nfe_regs
  import nfe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        done_i,
  output logic        start_o,
  output logic        load_o,
  output nfe_cfg_t    cfg_o
);
  logic     start_q;
  nfe_cfg_t cfg_q;

  assign load_o = cfg_we && !start_q && (cfg_addr == A_CTRL) && cfg_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      cfg_q   <= '0;
    end else begin
      if (done_i) start_q <= 1'b0;
      if (cfg_we && !start_q) begin
        case (cfg_addr)
          A_CTRL: if (cfg_wdata[0]) start_q <= 1'b1;
          A_MODE: begin
            cfg_q.enable <= cfg_wdata[0];
            cfg_q.wpost  <= cfg_wdata[1];
            cfg_q.wide   <= cfg_wdata[2];
            cfg_q.cs     <= cfg_wdata[4 +: CS_W];
            cfg_q.thr    <= cfg_wdata[8 +: THR_W];
          end
          A_CNT:  cfg_q.count <= cfg_wdata[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      A_CTRL: cfg_rdata[0] = start_q;
      A_MODE: begin
        cfg_rdata[0]           = cfg_q.enable;
        cfg_rdata[1]           = cfg_q.wpost;
        cfg_rdata[2]           = cfg_q.wide;
        cfg_rdata[4 +: CS_W]   = cfg_q.cs;
        cfg_rdata[8 +: THR_W]  = cfg_q.thr;
      end
      A_CNT:  cfg_rdata[CNT_W-1:0] = cfg_q.count;
      default: ;
    endcase
  end

  assign start_o = start_q;
  assign cfg_o   = cfg_q;

  // R1: configuration is frozen while the engine runs
  p_cfg_locked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && $past(start_q)) |-> $stable(cfg_q));
  // R11: a completion clears start on the next edge
  p_auto_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> !start_q);
endmodule

// File: rtl/nfe_byte_fifo.sv
module nfe_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int NIN   = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int LVLW = $clog2(DEPTH + 1),
  localparam int NW   = $clog2(NIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [NW-1:0]    push_n,
  input  logic [NIN*8-1:0] push_data,
  input  logic             over_en,
  input  logic [7:0]       over_byte,
  input  logic [NW-1:0]    pop_n,
  output logic [NIN*8-1:0] peek,
  output logic [LVLW-1:0]  level
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [LVLW-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else if (flush) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_q + AW'(push_n);
      rd_q  <= rd_q + AW'(pop_n);
      lvl_q <= lvl_q + LVLW'(push_n) - LVLW'(pop_n);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NIN; i++) begin
      if (NW'(i) < push_n) mem[wr_q + AW'(i)] <= push_data[i*8 +: 8];
    end
    if (over_en) mem[wr_q + AW'(push_n) - AW'(1)] <= over_byte;
  end

  always_comb begin
    for (int j = 0; j < NIN; j++) peek[j*8 +: 8] = mem[rd_q + AW'(j)];
  end

  assign level = lvl_q;

  // R6: level never leaves the physical depth
  p_level_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LVLW'(DEPTH));
  // R9: pushes never exceed the free room; excess goes to the overwrite path
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> (LVLW'(push_n) <= LVLW'(DEPTH) - lvl_q));
  // R8: pops never exceed the stored bytes
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> (LVLW'(pop_n) <= lvl_q));
endmodule

// File: rtl/nfe_dev_seq.sv
module nfe_dev_seq
  import nfe_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int LVLW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             load,
  input  nfe_cfg_t         cfg,
  input  logic [LVLW-1:0]  level,
  input  logic [15:0]      peek16,
  output logic             dev_req,
  input  logic             dev_ack,
  output logic             dev_we,
  output logic [CS_W-1:0]  dev_cs,
  output logic             dev_wide,
  output logic [15:0]      dev_wdata,
  output logic [2:0]       push_n,
  output logic [2:0]       pop_n,
  output logic [CNT_W-1:0] remaining,
  output logic             done
);
  logic [CNT_W-1:0] rem_q;
  logic [LVLW-1:0]  bpt_l;
  logic [CNT_W-1:0] bpt_c;
  logic             room, xfer;

  assign bpt_l = cfg.wide ? LVLW'(2) : LVLW'(1);
  assign bpt_c = cfg.wide ? CNT_W'(2) : CNT_W'(1);
  assign room  = cfg.wpost ? (level >= bpt_l) : ((LVLW'(DEPTH) - level) >= bpt_l);

  assign dev_req   = start && (rem_q >= bpt_c) && room;
  assign xfer      = dev_req && dev_ack;
  assign dev_we    = cfg.wpost;
  assign dev_cs    = cfg.cs;
  assign dev_wide  = cfg.wide;
  assign dev_wdata = cfg.wide ? peek16 : {8'h00, peek16[7:0]};
  assign push_n    = (xfer && !cfg.wpost) ? 3'(bpt_l) : 3'd0;
  assign pop_n     = (xfer &&  cfg.wpost) ? 3'(bpt_l) : 3'd0;
  assign done      = start && (rem_q == '0) && (!cfg.wpost || level == '0);
  assign remaining = rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     rem_q <= '0;
    else if (load)  rem_q <= cfg.wide ? {cfg.count[CNT_W-2:0], 1'b0} : cfg.count;
    else if (xfer)  rem_q <= rem_q - bpt_c;
  end

  // R7: the remaining count only falls while running
  p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && $past(start)) |-> (rem_q <= $past(rem_q)));
  // R12: no request once the count is used up
  p_req_needs_count_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_q == '0) |-> !dev_req);
endmodule

// File: rtl/nand_fifo_engine.sv
module nand_fifo_engine
  import nfe_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int LVLW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             host_valid,
  output logic             host_ready,
  input  logic             host_write,
  input  logic [CS_W-1:0]  host_cs,
  input  logic [NLANE-1:0] host_be,
  input  logic [31:0]      host_wdata,
  output logic             host_rvalid,
  output logic [31:0]      host_rdata,
  output logic             dev_req,
  input  logic             dev_ack,
  output logic             dev_we,
  output logic [CS_W-1:0]  dev_cs,
  output logic             dev_wide,
  output logic [15:0]      dev_wdata,
  input  logic [15:0]      dev_rdata,
  output logic [LVLW-1:0]  fifo_ptr,
  output logic [CNT_W-1:0] count_left,
  output logic             busy,
  output logic             thr_req
);
  nfe_cfg_t        cfg;
  logic            start, load, done;
  logic [LVLW-1:0] level, free_b;
  logic [31:0]     peek;
  logic [2:0]      dev_push_n, dev_pop_n, f_push_n, f_pop_n;
  logic [2:0]      nb, popn, nfit;
  logic            acc, rd_acc, wr_acc, over;
  logic [7:0]      ord_b  [NLANE];
  logic [7:0]      peek_b [NLANE];
  logic [7:0]      rb     [NLANE];
  logic [7:0]      last_q;
  logic [31:0]     rd_word;
  logic [1:0]      lastidx;
  logic [THR_W:0]  thr_bytes;

  nfe_regs u_regs (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .done_i(done), .start_o(start), .load_o(load), .cfg_o(cfg)
  );

  nfe_dev_seq #(.DEPTH(DEPTH)) u_seq (
    .clk, .rst_n, .start, .load, .cfg, .level, .peek16(peek[15:0]),
    .dev_req, .dev_ack, .dev_we, .dev_cs, .dev_wide, .dev_wdata,
    .push_n(dev_push_n), .pop_n(dev_pop_n), .remaining(count_left), .done
  );

  nfe_byte_fifo #(.DEPTH(DEPTH), .NIN(NLANE)) u_fifo (
    .clk, .rst_n, .flush(load),
    .push_n(f_push_n),
    .push_data(cfg.wpost ? {ord_b[3], ord_b[2], ord_b[1], ord_b[0]} : {16'h0000, dev_rdata}),
    .over_en(wr_acc && over), .over_byte(ord_b[2'(nb - 3'd1)]),
    .pop_n(f_pop_n), .peek, .level
  );

  assign host_ready = cfg.enable && (host_cs == cfg.cs);
  assign acc    = host_valid && host_ready;
  assign rd_acc = acc && !host_write && !cfg.wpost;
  assign wr_acc = acc &&  host_write &&  cfg.wpost;
  assign nb     = 3'($countones(host_be));
  assign free_b = LVLW'(DEPTH) - level;
  assign popn   = (LVLW'(nb) <= level) ? nb : 3'(level);
  assign nfit   = (LVLW'(nb) <= free_b) ? nb : 3'(free_b);
  assign over   = LVLW'(nb) > free_b;
  assign lastidx = 2'(popn - 3'd1);

  assign f_push_n = cfg.wpost ? (wr_acc ? nfit : 3'd0) : dev_push_n;
  assign f_pop_n  = cfg.wpost ? dev_pop_n : (rd_acc ? popn : 3'd0);

  // pack write lanes into FIFO order, lowest enabled lane first
  always_comb begin
    logic [2:0] idx;
    idx = '0;
    for (int k = 0; k < NLANE; k++) ord_b[k] = 8'h00;
    for (int k = 0; k < NLANE; k++) begin
      if (host_be[k]) begin
        ord_b[idx[1:0]] = host_wdata[k*8 +: 8];
        idx = idx + 3'd1;
      end
    end
  end

  // read bytes in FIFO order, repeating the last byte past the available data
  always_comb begin
    for (int j = 0; j < NLANE; j++) begin
      peek_b[j] = peek[j*8 +: 8];
      if (3'(j) < popn)    rb[j] = peek_b[j];
      else if (popn != 0)  rb[j] = peek_b[lastidx];
      else                 rb[j] = last_q;
    end
  end

  always_comb begin
    logic [2:0] idx;
    idx = '0;
    rd_word = '0;
    for (int k = 0; k < NLANE; k++) begin
      if (host_be[k]) begin
        rd_word[k*8 +: 8] = rb[idx[1:0]];
        idx = idx + 3'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q      <= 8'h00;
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      if (load)                       last_q <= 8'h00;
      else if (rd_acc && popn != 0)   last_q <= peek_b[lastidx];
      host_rvalid <= acc && !host_write;
      if (acc && !host_write) host_rdata <= cfg.wpost ? 32'h0 : rd_word;
    end
  end

  assign fifo_ptr  = cfg.wpost ? free_b : level;
  assign thr_bytes = cfg.wide ? {cfg.thr, 1'b0} : {1'b0, cfg.thr};
  assign thr_req   = cfg.enable && (int'(fifo_ptr) >= int'(thr_bytes));
  assign busy      = start;

  // R13: read data comes one cycle after an accepted read
  p_rdata_timing_r13: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |-> $past(host_valid && host_ready && !host_write));
  // R2: a chip-select mismatch is never accepted
  p_cs_filter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_cs != cfg.cs) |-> !host_ready);
endmodule

// File: tb/nand_fifo_engine_tb.sv
`timescale 1ns/1ps
module nand_fifo_engine_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        cfg_we = 0;
  logic [1:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic        host_valid = 0, host_ready, host_write = 0, host_rvalid;
  logic [2:0]  host_cs = 0;
  logic [3:0]  host_be = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic        dev_req, dev_ack = 0, dev_we, dev_wide;
  logic [2:0]  dev_cs;
  logic [15:0] dev_wdata, dev_rdata;
  logic [6:0]  fifo_ptr;
  logic [13:0] count_left;
  logic        busy, thr_req;

  int n_chk = 0, n_err = 0, n_xfer = 0, pend_n = 0, cycles = 0;
  logic [7:0] dv_base = 8'h10, dv_cnt = 0;
  logic dev_hold = 0;
  logic [2:0] exp_cs = 0;
  logic [31:0] rd_q[$];
  string rd_tag[$];
  logic [7:0] dev_q[$];

  assign dev_rdata = {dv_base + dv_cnt + 8'd1, dv_base + dv_cnt};

  nand_fifo_engine dut_i (.*);

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // host read monitor (scoreboard)
  always @(negedge clk) begin
    if (rst_n && host_rvalid) begin
      if (rd_q.size() == 0) chk("R13 unexpected read data", host_rvalid, 0);
      else chk(rd_tag.pop_front(), host_rdata, rd_q.pop_front());
    end
  end

  // device model and write-side monitor
  always @(negedge clk) begin
    logic ack_n;
    if (pend_n != 0) begin dv_cnt = dv_cnt + 8'(pend_n); pend_n = 0; end
    ack_n = !dev_hold;
    dev_ack <= ack_n;
    if (rst_n && dev_req && ack_n) begin
      n_xfer++;
      chk("R12 dev_cs", 32'(dev_cs), 32'(exp_cs));
      if (dev_we) begin
        if (dev_q.size() == 0) chk("R9 unexpected device write", 1, 0);
        else chk("R4/R9 device write byte", 32'(dev_wdata[7:0]), 32'(dev_q.pop_front()));
        if (dev_wide) begin
          if (dev_q.size() == 0) chk("R5 unexpected device write", 1, 0);
          else chk("R5 device high byte", 32'(dev_wdata[15:8]), 32'(dev_q.pop_front()));
        end
      end else pend_n = dev_wide ? 2 : 1;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic cfg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic cfg_rd(input string rq, input logic [1:0] a, input logic [31:0] exp);
    @(negedge clk); cfg_addr = a; #1;
    chk(rq, cfg_rdata, exp);
  endtask

  task automatic host_rd(input string rq, input logic [2:0] cs, input logic [3:0] be,
                         input logic [31:0] exp);
    @(negedge clk); host_valid = 1; host_write = 0; host_cs = cs; host_be = be; #1;
    chk("R13 ready on hit", 32'(host_ready), 1);
    rd_q.push_back(exp); rd_tag.push_back(rq);
    @(negedge clk); host_valid = 0;
  endtask

  task automatic host_wr(input logic [2:0] cs, input logic [3:0] be, input logic [31:0] d,
                         input bit expect_q);
    @(negedge clk); host_valid = 1; host_write = 1; host_cs = cs; host_be = be; host_wdata = d;
    if (expect_q) for (int k = 0; k < 4; k++) if (be[k]) dev_q.push_back(d[k*8 +: 8]);
    @(negedge clk); host_valid = 0; host_write = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    chk("R11 engine stops", 32'(busy), 0);
  endtask

  task automatic dev_reset(input logic [7:0] base);
    @(posedge clk); dv_cnt = 0; dv_base = base; n_xfer = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R6 reset fifo_ptr", 32'(fifo_ptr), 0);
    chk("R7 reset count_left", 32'(count_left), 0);
    chk("R11 reset busy", 32'(busy), 0);
    chk("R10 reset thr_req", 32'(thr_req), 0);
    cfg_rd("R1 reset mode reg", 2'd1, 0);

    // Test A: 8-bit prefetch, cs 3, 10 bytes, threshold 4
    exp_cs = 3; dev_hold = 0; dev_reset(8'h10);
    cfg_wr(2'd1, 32'h0000_0431);
    cfg_wr(2'd2, 32'd10);
    cfg_rd("R1 mode readback", 2'd1, 32'h0000_0431);
    cfg_wr(2'd0, 32'd1);
    wait_idle();
    chk("R4 byte transfer count", n_xfer, 10);
    chk("R7 count drained", 32'(count_left), 0);
    chk("R6 bytes available", 32'(fifo_ptr), 10);
    chk("R10 thr_req above threshold", 32'(thr_req), 1);
    chk("R4 dev_wide low", 32'(dev_wide), 0);
    host_rd("R3 word read", 3'd3, 4'hF, 32'h1312_1110);
    host_rd("R3 half read", 3'd3, 4'h3, 32'h0000_1514);
    host_rd("R3 upper lane byte", 3'd3, 4'h4, 32'h0016_0000);
    @(negedge clk);
    chk("R6 level after reads", 32'(fifo_ptr), 3);
    chk("R10 thr_req below threshold", 32'(thr_req), 0);
    host_rd("R8 partial repeat", 3'd3, 4'hF, 32'h1919_1817);
    host_rd("R8 empty repeat", 3'd3, 4'h3, 32'h0000_1919);
    @(negedge clk); host_valid = 1; host_cs = 3'd2; host_be = 4'hF; #1;
    chk("R2 foreign cs not ready", 32'(host_ready), 0);
    @(negedge clk); host_valid = 0;
    chk("R2 foreign cs no read data", 32'(host_rvalid), 0);

    // Test B: 16-bit prefetch, locked configuration
    exp_cs = 5; dev_hold = 1; dev_reset(8'hA0);
    cfg_wr(2'd1, 32'h0000_0255);
    cfg_wr(2'd2, 32'd3);
    cfg_wr(2'd0, 32'd1);
    @(negedge clk);
    chk("R7 count in bytes", 32'(count_left), 6);
    chk("R12 request with room", 32'(dev_req), 1);
    chk("R5 dev_wide high", 32'(dev_wide), 1);
    cfg_wr(2'd1, 32'h0000_0000);
    cfg_wr(2'd2, 32'd99);
    cfg_rd("R1 mode write ignored", 2'd1, 32'h0000_0255);
    cfg_rd("R1 count write ignored", 2'd2, 32'd3);
    dev_hold = 0;
    wait_idle();
    chk("R5 word transfer count", n_xfer, 3);
    chk("R6 bytes from words", 32'(fifo_ptr), 6);
    chk("R10 word threshold met", 32'(thr_req), 1);
    host_rd("R5 low byte first", 3'd5, 4'hF, 32'hA3A2_A1A0);
    @(negedge clk);
    chk("R10 word threshold not met", 32'(thr_req), 0);
    host_rd("R5 last word", 3'd5, 4'h3, 32'h0000_A5A4);

    // Test C: 8-bit write posting, cs 1, 6 bytes, threshold 60
    exp_cs = 1; dev_hold = 1; dev_reset(8'h00);
    cfg_wr(2'd1, 32'h0000_3C13);
    cfg_wr(2'd2, 32'd6);
    cfg_wr(2'd0, 32'd1);
    chk("R6 free slots empty", 32'(fifo_ptr), 64);
    host_wr(3'd1, 4'hF, 32'h4433_2211, 1);
    chk("R6 free after word", 32'(fifo_ptr), 60);
    chk("R10 free at threshold", 32'(thr_req), 1);
    host_wr(3'd1, 4'hA, 32'h6600_5500, 1);
    chk("R3 sparse lanes two bytes", 32'(fifo_ptr), 58);
    chk("R10 free below threshold", 32'(thr_req), 0);
    chk("R12 dev_we in posting", 32'(dev_we), 1);
    dev_hold = 0;
    wait_idle();
    chk("R11 all bytes drained", dev_q.size(), 0);
    chk("R7 posting count drained", 32'(count_left), 0);

    // Test D: overfill, overwrite of the last location
    dev_hold = 1; dev_reset(8'h00);
    cfg_wr(2'd1, 32'h0000_0013);
    cfg_wr(2'd2, 32'd64);
    cfg_wr(2'd0, 32'd1);
    for (int w = 0; w < 16; w++) begin
      logic [7:0] b0;
      b0 = 8'(w * 4);
      host_wr(3'd1, 4'hF, {b0 + 8'd3, b0 + 8'd2, b0 + 8'd1, b0}, 1);
    end
    chk("R6 full has no free", 32'(fifo_ptr), 0);
    host_wr(3'd1, 4'h1, 32'h0000_00EE, 0);
    dev_q[dev_q.size() - 1] = 8'hEE;
    chk("R9 full write keeps level", 32'(fifo_ptr), 0);
    host_wr(3'd1, 4'h3, 32'h0000_7766, 0);
    dev_q[dev_q.size() - 1] = 8'h77;
    chk("R9 second overwrite keeps level", 32'(fifo_ptr), 0);
    dev_hold = 0;
    wait_idle();
    chk("R9 drained count", n_xfer, 64);
    chk("R9 no leftover expected bytes", dev_q.size(), 0);

    repeat (4) @(negedge clk);
    chk("R13 all reads returned", rd_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule